// File: doc/BRIEF.md
# Key-Locked Bus Control Register

This block is a small control register file that sits on a 32-bit register bus. It is placed in front of an external memory interface. It holds a chip-select configuration word. Bit 2 of that word is the flash write-enable, and it drives the `flash_we_o` pin directly. That one bit is guarded by a key register. While the key register is closed, a write to the configuration word updates every other bit but leaves the write-enable bit alone. Writing the 32-bit value 0x0000A05F to the key register opens it. Writing any other value, including zero, closes it again.

Software is expected to write the configuration word and then read it back. If the write-enable bit did not change, software writes the key, repeats the configuration write, and then writes zero to relock.

The bus has no back-pressure. A request is accepted in the cycle it is presented, and a write takes effect at that clock edge. A read returns its data with `rvalid_o` exactly one cycle after the request. A key write affects the next bus access at the earliest.

Top module: `keylock_bus_ctrl`

## Requirements
- R1: After reset the key register is closed, the configuration word is 0, `flash_we_o` is 0, and a read of the key register (byte offset 0x4) returns 0.
- R2: A write of exactly 0x0000A05F to the key register opens it. A later read of the key register returns bit 16 set and 0xA05F in bits 15:0.
- R3: A write of any other value to the key register closes it. This includes zero. A later read returns bit 16 clear and the low 16 bits of the written value in bits 15:0.
- R4: While the key register is closed, a write to the configuration word (byte offset 0x0) updates every bit except bit 2, which keeps its old value. This holds whether the write would set bit 2 or clear it.
- R5: While the key register is open, a write to the configuration word updates all 32 bits. Bit 2 can be both set and cleared.
- R6: `flash_we_o` always equals bit 2 of the configuration word as read back over the bus.
- R7: A read request produces `rvalid_o` high with its data in the next cycle. A read of an unmapped offset (for example 0x8) returns 0, and a write to an unmapped offset changes no register.
- R8: A key-register write whose low 16 bits equal 0xA05F but whose upper bits are not zero does not open the key register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access request, accepted in the same cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte offset: 0x0 configuration word, 0x4 key register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while rvalid_o is high |
| rvalid_o | output | 1 | High one cycle after a read request |
| flash_we_o | output | 1 | Flash write-enable, equal to configuration bit 2 |

## Verification
The bench uses the default parameters: a 32-bit data bus, a 16-bit key of 0xA05F, and the protected bit at position 2. With these values the exact lock/unlock sequence that software would use can be driven. A behavioural model tracks the configuration word, the key state and the pending read. It is compared with `flash_we_o`, `rvalid_o` and `rdata_o` on every clock. The directed steps cover several cases:
- blocked sets and blocked clears;
- a key with stray upper bits;
- a key followed at once by a closing write;
- unmapped accesses.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_KEY  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/keylock_gate.sv
module keylock_gate #(
  parameter int          DATA_W = 32,
  parameter int          KEY_W  = 16,
  parameter logic [15:0] KEY    = 16'hA05F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              open_q,
  output logic [KEY_W-1:0]  echo_q
);
  localparam logic [DATA_W-1:0] FULL_KEY = DATA_W'(KEY);

  logic key_hit;
  assign key_hit = (wdata == FULL_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      echo_q <= '0;
    end else if (wr_en) begin
      open_q <= key_hit;
      echo_q <= wdata[KEY_W-1:0];
    end
  end

  // R2: the exact key opens the gate
  assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wdata == FULL_KEY) |=> open_q);
  // R3 / R8: any other value closes it
  assert_other_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wdata != FULL_KEY) |=> !open_q);
  // R3: without a key-register write the state holds
  assert_gate_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(open_q));
endmodule

// File: rtl/keylock_cfg_reg.sv
module keylock_cfg_reg #(
  parameter int          DATA_W = 32,
  parameter int          WE_BIT = 2,
  parameter logic [31:0] RST_VAL = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              open_i,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg_q
);
  localparam logic [DATA_W-1:0] PROT_MASK = DATA_W'(1) << WE_BIT;

  logic [DATA_W-1:0] cfg_next;

  always_comb begin
    if (open_i) cfg_next = wdata;
    else        cfg_next = (wdata & ~PROT_MASK) | (cfg_q & PROT_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= DATA_W'(RST_VAL);
    else if (wr_en) cfg_q <= cfg_next;
  end

  // R4: closed gate keeps the protected bit
  assert_locked_keeps_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !open_i |=> cfg_q[WE_BIT] == $past(cfg_q[WE_BIT]));
  // R5: open gate takes the whole word
  assert_open_takes_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && open_i |=> cfg_q == $past(wdata));
endmodule

// File: rtl/keylock_read_port.sv
module keylock_read_port
  import keylock_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int KEY_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] cfg_i,
  input  logic              open_i,
  input  logic [KEY_W-1:0]  echo_i,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);
  localparam int PAD_W = DATA_W - KEY_W - 1;

  logic [DATA_W-1:0] mux;

  always_comb begin
    unique case (sel)
      SEL_CFG: mux = cfg_i;
      SEL_KEY: mux = {{PAD_W{1'b0}}, open_i, echo_i};
      default: mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= mux;
    end
  end

  // R7: every read is answered in the next cycle
  assert_read_answered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid_q);
  assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid_q);
endmodule

// File: rtl/keylock_bus_ctrl.sv
module keylock_bus_ctrl
  import keylock_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 4,
  parameter int          KEY_W    = 16,
  parameter logic [15:0] KEY      = 16'hA05F,
  parameter int          WE_BIT   = 2,
  parameter int          CFG_OFS  = 0,
  parameter int          KEY_OFS  = 4,
  parameter logic [31:0] CFG_RST  = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              flash_we_o
);
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(CFG_OFS);
  localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(KEY_OFS);

  reg_sel_e          sel;
  logic              cfg_wr, key_wr, rd_en;
  logic              gate_open;
  logic [KEY_W-1:0]  key_echo;
  logic [DATA_W-1:0] cfg_q;

  always_comb begin
    if (addr_i == CFG_ADDR)      sel = SEL_CFG;
    else if (addr_i == KEY_ADDR) sel = SEL_KEY;
    else                         sel = SEL_NONE;
  end

  assign cfg_wr = req_i && we_i && (sel == SEL_CFG);
  assign key_wr = req_i && we_i && (sel == SEL_KEY);
  assign rd_en  = req_i && !we_i;

  keylock_gate #(.DATA_W(DATA_W), .KEY_W(KEY_W), .KEY(KEY)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(key_wr), .wdata(wdata_i),
    .open_q(gate_open), .echo_q(key_echo)
  );

  keylock_cfg_reg #(.DATA_W(DATA_W), .WE_BIT(WE_BIT), .RST_VAL(CFG_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .open_i(gate_open),
    .wdata(wdata_i), .cfg_q(cfg_q)
  );

  keylock_read_port #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel(sel), .cfg_i(cfg_q),
    .open_i(gate_open), .echo_i(key_echo), .rdata_q(rdata_o), .rvalid_q(rvalid_o)
  );

  assign flash_we_o = cfg_q[WE_BIT];

  // R6: a write-enable change needs an open gate and a configuration write
  assert_we_change_needs_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && gate_open) |=> $stable(flash_we_o));
endmodule

// File: tb/test_keylock_bus_ctrl.sv
`timescale 1ns/1ps
module test_keylock_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, flash_we;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keylock_bus_ctrl i_keylock_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .flash_we_o(flash_we)
  );

  // behavioural reference model
  logic [31:0] m_cfg = 32'h0;
  bit          m_open = 1'b0;
  logic [15:0] m_echo = 16'h0;
  bit          m_rvalid = 1'b0;
  logic [31:0] m_rdata = 32'h0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg <= 0; m_open <= 0; m_echo <= 0; m_rvalid <= 0;
    end else begin
      m_rvalid <= req && !we;
      if (req && !we) begin
        if (addr == 4'h0)      m_rdata <= m_cfg;
        else if (addr == 4'h4) m_rdata <= {15'h0, m_open, m_echo};
        else                   m_rdata <= 32'h0;
      end
      if (req && we && addr == 4'h0)
        m_cfg <= m_open ? wdata : {wdata[31:3], m_cfg[2], wdata[1:0]};
      if (req && we && addr == 4'h4) begin
        m_open <= (wdata == 32'h0000A05F);
        m_echo <= wdata[15:0];
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R6 flash_we", {31'h0, flash_we}, {31'h0, m_cfg[2]});
      check("R7 rvalid", {31'h0, rvalid}, {31'h0, m_rvalid});
      if (m_rvalid) check("R7 rdata", rdata, m_rdata);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
    #1;
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 flash_we", {31'h0, flash_we}, 32'h0);
    rd(4'h0, 32'h0, "R1 cfg");
    rd(4'h4, 32'h0, "R1 key");
    // R4 blocked set
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'hFFFF_FFFB, "R4 blocked set");
    // R2 unlock and R5 set
    wr(4'h4, 32'h0000_A05F);
    rd(4'h4, 32'h0001_A05F, "R2 key open");
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'hFFFF_FFFF, "R5 set");
    check("R6 pin high", {31'h0, flash_we}, 32'h1);
    // R3 relock by zero, R4 blocked clear
    wr(4'h4, 32'h0);
    rd(4'h4, 32'h0, "R3 zero relock");
    wr(4'h0, 32'h0);
    rd(4'h0, 32'h0000_0004, "R4 blocked clear");
    // R3 other value locks, immediately after key
    wr(4'h4, 32'h0000_A05F);
    wr(4'h4, 32'h0000_1234);
    rd(4'h4, 32'h0000_1234, "R3 other value");
    wr(4'h0, 32'h0000_0010);
    rd(4'h0, 32'h0000_0014, "R3 write after close");
    // R8 stray upper bits
    wr(4'h4, 32'h0001_A05F);
    rd(4'h4, 32'h0000_A05F, "R8 upper bits");
    wr(4'h0, 32'h0);
    rd(4'h0, 32'h0000_0004, "R8 still locked");
    // R5 clear, then reset sequence from software view
    wr(4'h4, 32'h0000_A05F);
    wr(4'h0, 32'h0000_0100);
    rd(4'h0, 32'h0000_0100, "R5 clear");
    check("R6 pin low", {31'h0, flash_we}, 32'h0);
    wr(4'h4, 32'h0);
    // R7 unmapped
    wr(4'h8, 32'hDEAD_BEEF);
    rd(4'h8, 32'h0, "R7 unmapped read");
    rd(4'h0, 32'h0000_0100, "R7 unmapped write ignored");
    rd(4'h4, 32'h0, "R7 key unchanged");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule